// File: doc/BRIEF.md
# Power Supply Fault Supervisor

A synchronous supervisor for a switching power supply. Its inputs are digital flags from external comparators: supply overvoltage, supply undervoltage lockout, overvoltage and undervoltage on a monitored output rail, overcurrent, and a power-on request. Every one of these passes through its own debounce filter. The filtered flags drive fault latches. The latches drive a main fault output, a secondary fault output and an output-enable signal. The block also produces a digital soft-start code that ramps up whenever the supply is allowed to run.

Faults fall into two classes. Overvoltage on the supply or on the rail is severe: it raises both fault outputs and stays latched until the supply drops into undervoltage lockout. Rail undervoltage and overcurrent raise only the main fault output. The restart-mode input picks how they recover: they either stay latched, or they clear after a restart delay, at which point the soft-start ramp begins again from zero. All delays are clock-count parameters. The ramp step is derived from the final code and the ramp length.

Top module: `psu_fault_supervisor`

## Requirements
- R1: An input's filtered level changes only after the raw input has held the new level for DEB_CYCLES consecutive clocks. A shorter glitch has no effect on any output.
- R2: While the filtered supply-undervoltage flag is high, all four outputs are 0. The lockout also clears every fault latch, so after it ends the outputs depend only on the current flags.
- R3: A filtered supply overvoltage sets both fault outputs to 1 and out_en_o to 0. This state holds after the flag falls and in either restart mode.
- R4: A filtered rail overvoltage produces the same latched result as R3.
- R5: A filtered rail undervoltage sets fault_main_o to 1, keeps fault_aux_o at 0 and forces out_en_o to 0.
- R6: A filtered overcurrent sets fault_main_o to 1, keeps fault_aux_o at 0 and forces out_en_o to 0.
- R7: With restart_auto_i = 0, an undervoltage or overcurrent latch stays set indefinitely after its flag falls. Only lockout clears it.
- R8: With restart_auto_i = 1, an undervoltage or overcurrent latch with no overvoltage latch set clears after RESTART_CYCLES clocks, and the ramp restarts from 0. If the flag is still high at that moment, the latch re-sets in the same cycle and fault_main_o never drops.
- R9: While running, ss_code_o rises monotonically by STEP every TICK clocks. It saturates at FINAL_CODE.
- R10: With the filtered power request low, out_en_o and ss_code_o are 0. Overvoltage latches remain set.
- R11: out_en_o is 1 exactly when the filtered request is high, lockout is inactive and no fault latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req_i | input | 1 | Power-on request, 1 = run |
| supply_ov_i | input | 1 | Supply overvoltage flag |
| supply_uv_i | input | 1 | Supply undervoltage lockout flag |
| rail_ov_i | input | 1 | Monitored-rail overvoltage flag |
| rail_uv_i | input | 1 | Monitored-rail undervoltage flag |
| over_cur_i | input | 1 | Overcurrent flag |
| restart_auto_i | input | 1 | 1 = timed auto-restart, 0 = latched shutdown |
| fault_main_o | output | 1 | Main fault output |
| fault_aux_o | output | 1 | Secondary fault output (overvoltage only) |
| out_en_o | output | 1 | Output enable |
| ss_code_o | output | CODE_W | Soft-start reference code |

## Verification
The hardest state to reach from the ports is the moment an auto-restart timer expires while the rail-undervoltage flag is still high. The design must re-latch in that same cycle and never show a gap on the main fault output. The bench reaches this state by holding the flag high for longer than the restart delay, with the restart mode selected. It compares every cycle against a behavioural reference model, so a single-cycle drop is caught. Lockout clearing an overvoltage latch is reached the same way: the bench latches an overvoltage, drops the request, waits out several restart periods and then pulses the lockout flag.

// File: rtl/psu_fault_supervisor.sv
module psu_fault_supervisor #(
  parameter int DEB_CYCLES     = 16,
  parameter int RESTART_CYCLES = 125_000_000,
  parameter int RAMP_CYCLES    = 1_000_000,
  parameter int CODE_W         = 10,
  parameter int FINAL_CODE     = 640
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_req_i,
  input  logic              supply_ov_i,
  input  logic              supply_uv_i,
  input  logic              rail_ov_i,
  input  logic              rail_uv_i,
  input  logic              over_cur_i,
  input  logic              restart_auto_i,
  output logic              fault_main_o,
  output logic              fault_aux_o,
  output logic              out_en_o,
  output logic [CODE_W-1:0] ss_code_o
);
  localparam int NIN      = 6;
  localparam int DW       = $clog2(DEB_CYCLES + 1);
  localparam int RW       = $clog2(RESTART_CYCLES + 1);
  localparam int TICK_RAW = RAMP_CYCLES / FINAL_CODE;
  localparam int TICK     = (TICK_RAW < 1) ? 1 : TICK_RAW;
  localparam int STEP     = (TICK_RAW < 1) ? ((FINAL_CODE + RAMP_CYCLES - 1) / RAMP_CYCLES) : 1;
  localparam int TW       = $clog2(TICK + 1);

  logic [NIN-1:0] raw;
  assign raw = {over_cur_i, rail_uv_i, rail_ov_i, supply_uv_i, supply_ov_i, pwr_req_i};

  logic          filt [NIN];
  logic [DW-1:0] dcnt [NIN];

  for (genvar g = 0; g < NIN; g++) begin : g_deb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        filt[g] <= 1'b0;
        dcnt[g] <= '0;
      end else if (raw[g] == filt[g]) begin
        dcnt[g] <= '0;
      end else if (dcnt[g] == DW'(DEB_CYCLES - 1)) begin
        filt[g] <= raw[g];
        dcnt[g] <= '0;
      end else begin
        dcnt[g] <= dcnt[g] + 1'b1;
      end
    end
  end

  logic req_f, sov_f, suv_f, rov_f, ruv_f, oc_f;
  assign req_f = filt[0];
  assign sov_f = filt[1];
  assign suv_f = filt[2];
  assign rov_f = filt[3];
  assign ruv_f = filt[4];
  assign oc_f  = filt[5];

  logic              ovp_lat, flt_lat;
  logic [RW-1:0]     rcnt;
  logic [TW-1:0]     tcnt;
  logic [CODE_W-1:0] code;
  logic              soft_now, timing, expire, run;
  logic [CODE_W:0]   code_sum;

  assign soft_now = ruv_f | oc_f;
  assign timing   = flt_lat & restart_auto_i & ~ovp_lat;
  assign expire   = timing & (rcnt == RW'(RESTART_CYCLES - 1));
  assign run      = req_f & ~suv_f & ~ovp_lat & ~flt_lat;
  assign code_sum = {1'b0, code} + (CODE_W+1)'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovp_lat <= 1'b0;
      flt_lat <= 1'b0;
      rcnt    <= '0;
    end else if (suv_f) begin
      ovp_lat <= 1'b0;
      flt_lat <= 1'b0;
      rcnt    <= '0;
    end else begin
      ovp_lat <= ovp_lat | sov_f | rov_f;
      if (expire) begin
        flt_lat <= soft_now;
        rcnt    <= '0;
      end else begin
        flt_lat <= flt_lat | soft_now;
        rcnt    <= timing ? rcnt + 1'b1 : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
      tcnt <= '0;
    end else if (!run) begin
      code <= '0;
      tcnt <= '0;
    end else if (tcnt == TW'(TICK - 1)) begin
      tcnt <= '0;
      code <= (code_sum >= (CODE_W+1)'(FINAL_CODE)) ? CODE_W'(FINAL_CODE) : code_sum[CODE_W-1:0];
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end

  assign fault_main_o = ~suv_f & (ovp_lat | flt_lat);
  assign fault_aux_o  = ~suv_f & ovp_lat;
  assign out_en_o     = run;
  assign ss_code_o    = suv_f ? '0 : code;

  p_uvlo_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    suv_f |=> (!ovp_lat && !flt_lat));
  p_ovp_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_lat && !suv_f) |=> ovp_lat);
  p_restart_only_auto_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_lat) |-> ($past(suv_f) || $past(restart_auto_i)));
  p_code_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (code >= $past(code)));
  p_code_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    code <= CODE_W'(FINAL_CODE));
  p_en_off_on_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_lat) |-> !out_en_o);
endmodule

// File: tb/psu_fault_supervisor_tb.sv
`timescale 1ns/1ps
module psu_fault_supervisor_tb;
  localparam int DEB = 4, RST = 200, RAMP = 32, CW = 10, FIN = 512;
  localparam int TICK = (RAMP / FIN < 1) ? 1 : RAMP / FIN;
  localparam int STEP = (RAMP / FIN < 1) ? (FIN + RAMP - 1) / RAMP : 1;

  logic clk = 0, rst_n = 0;
  logic req = 0, sov = 0, suv = 0, rov = 0, ruv = 0, oc = 0, autom = 0;
  logic fm, fa, en;
  logic [CW-1:0] code;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  psu_fault_supervisor #(.DEB_CYCLES(DEB), .RESTART_CYCLES(RST), .RAMP_CYCLES(RAMP),
    .CODE_W(CW), .FINAL_CODE(FIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_req_i(req), .supply_ov_i(sov), .supply_uv_i(suv),
    .rail_ov_i(rov), .rail_uv_i(ruv), .over_cur_i(oc), .restart_auto_i(autom),
    .fault_main_o(fm), .fault_aux_o(fa), .out_en_o(en), .ss_code_o(code));

  // reference model: 0 req,1 sov,2 suv,3 rov,4 ruv,5 oc
  bit lvl [6] = '{default: 0};
  int run_len [6] = '{default: 0};
  bit m_ovp = 0, m_soft = 0;
  int m_wait = 0, m_code = 0, m_tick = 0;

  function automatic bit m_run();
    return lvl[0] && !lvl[2] && !m_ovp && !m_soft;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (lvl[i]) begin lvl[i] = 0; run_len[i] = 0; end
      m_ovp = 0; m_soft = 0; m_wait = 0; m_code = 0; m_tick = 0;
    end else begin
      bit r [6];
      bit running, ovp_old;
      r = '{req, sov, suv, rov, ruv, oc};
      running = m_run();
      ovp_old = m_ovp;
      if (lvl[2]) begin
        m_ovp = 0; m_soft = 0; m_wait = 0;
      end else begin
        m_ovp = m_ovp || lvl[1] || lvl[3];
        if (m_soft && autom && !ovp_old) begin
          m_wait++;
          if (m_wait == RST) begin m_wait = 0; m_soft = lvl[4] || lvl[5]; end
        end else begin
          m_wait = 0;
          m_soft = m_soft || lvl[4] || lvl[5];
        end
      end
      if (!running) begin
        m_code = 0; m_tick = 0;
      end else begin
        m_tick++;
        if (m_tick == TICK) begin
          m_tick = 0;
          m_code = (m_code + STEP > FIN) ? FIN : m_code + STEP;
        end
      end
      for (int i = 0; i < 6; i++) begin
        if (r[i] == lvl[i]) run_len[i] = 0;
        else begin
          run_len[i]++;
          if (run_len[i] == DEB) begin lvl[i] = r[i]; run_len[i] = 0; end
        end
      end
    end
  end

  always @(negedge clk) begin
    int em, ea, ee, ec;
    em = (!lvl[2] && (m_ovp || m_soft)) ? 1 : 0;
    ea = (!lvl[2] && m_ovp) ? 1 : 0;
    ee = m_run() ? 1 : 0;
    ec = lvl[2] ? 0 : m_code;
    checks++;
    if (fm !== em[0]) begin failures++; $display("FAIL R5 ref main fault act=%0d exp=%0d t=%0t", fm, em, $time); end
    if (fa !== ea[0]) begin failures++; $display("FAIL R3 ref aux fault act=%0d exp=%0d t=%0t", fa, ea, $time); end
    if (en !== ee[0]) begin failures++; $display("FAIL R11 ref out_en act=%0d exp=%0d t=%0t", en, ee, $time); end
    if (code !== CW'(ec)) begin failures++; $display("FAIL R9 ref code act=%0d exp=%0d t=%0t", code, ec, $time); end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic outs(input string tag, input int m, input int a, input int e, input int c);
    chk({tag, " main"}, fm, m);
    chk({tag, " aux"}, fa, a);
    chk({tag, " en"}, en, e);
    if (c >= 0) chk({tag, " code"}, code, c);
  endtask

  initial begin
    tick(5); rst_n = 1; tick(2);
    outs("R2 reset", 0, 0, 0, 0);
    req = 1; tick(3); req = 0; tick(5);
    outs("R1 req glitch", 0, 0, 0, 0);
    req = 1; tick(50);
    outs("R9 R11 ramp done", 0, 0, 1, FIN);
    oc = 1; tick(2); oc = 0; tick(6);
    outs("R1 oc glitch", 0, 0, 1, FIN);
    oc = 1; tick(8);
    outs("R6 overcurrent", 1, 0, 0, 0);
    oc = 0; tick(300);
    outs("R7 latched", 1, 0, 0, 0);
    suv = 1; tick(8);
    outs("R2 lockout", 0, 0, 0, 0);
    suv = 0; tick(50);
    outs("R2 cleared", 0, 0, 1, FIN);
    autom = 1; ruv = 1; tick(8); ruv = 0;
    outs("R5 rail uv", 1, 0, 0, 0);
    tick(250);
    outs("R8 restart", 0, 0, 1, FIN);
    ruv = 1; tick(8);
    outs("R5 rail uv again", 1, 0, 0, 0);
    tick(250);
    outs("R8 relatch", 1, 0, 0, 0);
    ruv = 0; tick(260);
    outs("R8 recovered", 0, 0, 1, FIN);
    sov = 1; tick(8); sov = 0;
    outs("R3 supply ov", 1, 1, 0, 0);
    req = 0; tick(10);
    outs("R10 ov kept", 1, 1, 0, 0);
    tick(300);
    outs("R3 no auto clear", 1, 1, 0, 0);
    suv = 1; tick(8); suv = 0; req = 1; tick(50);
    outs("R2 ov cleared", 0, 0, 1, FIN);
    rov = 1; tick(8); rov = 0;
    outs("R4 rail ov", 1, 1, 0, 0);
    suv = 1; tick(8); suv = 0; tick(50);
    outs("R4 cleared by lockout", 0, 0, 1, FIN);
    req = 0; tick(10);
    outs("R10 req off", 0, 0, 0, 0);
    req = 1; tick(DEB + 4);
    chk("R9 mid ramp", (code > 0 && code < FIN) ? 1 : 0, 1);
    tick(40);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100_000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule